// File: doc/BRIEF.md
# Programmable Video Sync Pulse Generator

This block builds the timing pulses of a video raster from one free-running position counter that runs on a clock at four times the pixel rate. It produces five outputs: composite sync, horizontal blank, vertical blank, a sync-tip clamp pulse and a burst gate that can also act as a back-porch clamp. Every output comes from a register that is clocked by the 4X clock.

Parallel configuration inputs set the following:
- the line length, as an 11-bit code;
- the video standard whose default line length applies when that code is zero;
- a vertical blanking interval of 9 or 16 lines;
- interlaced or progressive scan;
- one polarity bit for each output group;
- the burst gate length;
- whether composite sync is regenerated inside the block or taken from a raw separated-sync input.

Configuration is expected to change only while reset is held. The frame length in lines is a parameter and must be odd.

Top module: `cvp_sync_gen`

## Requirements
- R1: With a nonzero `line_code` C, a line lasts 2·(C+1024) clocks. The horizontal position h counts 0 to that length minus 1 and then wraps to 0. On each wrap the line counter v advances, and it returns to 0 after line LINES−1.
- R2: With `line_code` = 0, the line length is 3432 clocks when `std_pal` = 0 and 3456 clocks when `std_pal` = 1. These are 858 and 864 pixels.
- R3: The sync clamp is active for 32 ≤ h < 224. The burst gate is active from h = 288 for 128 clocks when `burst_long` = 0, and for 256 clocks when `burst_long` = 1.
- R4: Horizontal blank is active for h < 560 and for h ≥ line length − 64.
- R5: Let HL be the half-line index 2·v + (h ≥ half the line length). Vertical blank is active for HL < 2·N, where N = 9 when `vblank_long` = 0 and N = 16 when it is 1. With `progressive` = 1, this is the only vertical blank window.
- R6: The vertical sync region is HL < 6. Inside it, regenerated composite sync is active when q < half-line − 128, where q is h measured from the start of the current half line. Outside it, regenerated composite sync is active for h < 256.
- R7: With `progressive` = 0, the second field repeats the sync region and the blank window starting at HL = LINES, which is the middle of line (LINES−1)/2. This second window covers HL from LINES to LINES+6 for sync and from LINES to LINES+2·N for blank.
- R8: `pol[0]` sets the polarity of composite sync, `pol[1]` sets horizontal and vertical blank, and `pol[2]` sets both clamp outputs. A value of 1 means active-high and 0 means active-low.
- R9: When `csync_raw_sel` = 1, `csync` carries `raw_sync` (active-high) as sampled at the previous clock edge, with the `pol[0]` polarity applied.
- R10: While `rst` is high, the counters are 0 and every output sits at its inactive level. Each output reflects the counter position of the previous clock, so in the first cycle after reset it shows position (h=0, v=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4X pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_code | input | 11 | Line length code; 0 selects the standard's default |
| std_pal | input | 1 | Default standard: 0 gives 858 pixels, 1 gives 864 pixels |
| vblank_long | input | 1 | Blank lines: 0 gives 9, 1 gives 16 |
| progressive | input | 1 | 1 selects non-interlaced frames |
| pol | input | 3 | Polarity for composite sync, blanks and clamps |
| burst_long | input | 1 | 1 selects the long back-porch gate |
| csync_raw_sel | input | 1 | 1 routes raw separated sync to `csync` |
| raw_sync | input | 1 | Raw separated sync, active-high |
| csync | output | 1 | Composite sync |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| sclamp | output | 1 | Sync-tip clamp |
| bclamp | output | 1 | Burst gate or back-porch clamp |

## Verification
Each output is registered once after the position counter, so the value seen after the k-th clock edge following reset release belongs to position k−1. The bench keeps a position index that starts at 0 on the first edge and samples on the falling edge, where that relation holds exactly. Raw sync passthrough is due one edge after `raw_sync` is driven, so each falling-edge sample is compared with the value driven at the previous falling edge. Mismatches from the full-frame sweeps are collected per line and per output, and each line is reported as one check that names the first cycle where it differs.

// File: rtl/cvp_sync_gen.sv
module cvp_sync_gen #(
  parameter int LINES = 525
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [10:0] line_code,
  input  logic        std_pal,
  input  logic        vblank_long,
  input  logic        progressive,
  input  logic [2:0]  pol,
  input  logic        burst_long,
  input  logic        csync_raw_sel,
  input  logic        raw_sync,
  output logic        csync,
  output logic        hblank,
  output logic        vblank,
  output logic        sclamp,
  output logic        bclamp
);
  localparam int H_W  = 13;
  localparam int V_W  = $clog2(LINES);
  localparam int HL_W = V_W + 2;

  localparam logic [H_W-1:0] DEF_NTSC  = H_W'(3432);
  localparam logic [H_W-1:0] DEF_PAL   = H_W'(3456);
  localparam logic [H_W-1:0] CODE_BASE = H_W'(2048);
  localparam logic [H_W-1:0] HS_END    = H_W'(256);
  localparam logic [H_W-1:0] SC_BEG    = H_W'(32);
  localparam logic [H_W-1:0] SC_END    = H_W'(224);
  localparam logic [H_W-1:0] BG_BEG    = H_W'(288);
  localparam logic [H_W-1:0] BG_SHORT  = H_W'(288 + 128);
  localparam logic [H_W-1:0] BG_LONG   = H_W'(288 + 256);
  localparam logic [H_W-1:0] HB_END    = H_W'(560);
  localparam logic [H_W-1:0] HB_FP     = H_W'(64);
  localparam logic [H_W-1:0] BROAD_GAP = H_W'(128);

  localparam logic [V_W-1:0]  LAST_V   = V_W'(LINES - 1);
  localparam logic [HL_W-1:0] VS_HL    = HL_W'(6);
  localparam logic [HL_W-1:0] F1_HL    = HL_W'(LINES);
  localparam logic [HL_W-1:0] F1_VS_HL = HL_W'(LINES + 6);
  localparam logic [HL_W-1:0] VB_S_HL  = HL_W'(18);
  localparam logic [HL_W-1:0] VB_L_HL  = HL_W'(32);

  logic [H_W-1:0]  hcnt, line_len, half, q;
  logic [V_W-1:0]  vcnt;
  logic [HL_W-1:0] hl, vb_hl;
  logic            upper, in_vs, in_vb, regen;
  logic            cs_q, hb_q, vb_q, sc_q, bg_q;

  assign line_len = (line_code == 11'd0) ? (std_pal ? DEF_PAL : DEF_NTSC)
                                         : {1'b0, line_code, 1'b0} + CODE_BASE;
  assign half  = line_len >> 1;
  assign upper = hcnt >= half;
  assign q     = upper ? hcnt - half : hcnt;
  assign hl    = {1'b0, vcnt, upper};
  assign vb_hl = vblank_long ? VB_L_HL : VB_S_HL;

  assign in_vs = (hl < VS_HL) ||
                 (!progressive && hl >= F1_HL && hl < F1_VS_HL);
  assign in_vb = (hl < vb_hl) ||
                 (!progressive && hl >= F1_HL && hl < F1_HL + vb_hl);
  assign regen = in_vs ? (q < half - BROAD_GAP) : (hcnt < HS_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (hcnt == line_len - H_W'(1)) begin
      hcnt <= '0;
      vcnt <= (vcnt == LAST_V) ? '0 : vcnt + V_W'(1);
    end else begin
      hcnt <= hcnt + H_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b0;
      hb_q <= 1'b0;
      vb_q <= 1'b0;
      sc_q <= 1'b0;
      bg_q <= 1'b0;
    end else begin
      cs_q <= csync_raw_sel ? raw_sync : regen;
      hb_q <= (hcnt < HB_END) || (hcnt >= line_len - HB_FP);
      vb_q <= in_vb;
      sc_q <= (hcnt >= SC_BEG) && (hcnt < SC_END);
      bg_q <= (hcnt >= BG_BEG) && (hcnt < (burst_long ? BG_LONG : BG_SHORT));
    end
  end

  assign csync  = ~(cs_q ^ pol[0]);
  assign hblank = ~(hb_q ^ pol[1]);
  assign vblank = ~(vb_q ^ pol[1]);
  assign sclamp = ~(sc_q ^ pol[2]);
  assign bclamp = ~(bg_q ^ pol[2]);
endmodule

module cvp_sync_gen_chk #(
  parameter int LINES = 525
) (
  input logic        clk,
  input logic        rst,
  input logic [12:0] hcnt,
  input logic [12:0] line_len,
  input logic [$clog2(LINES)-1:0] vcnt,
  input logic        csync_raw_sel,
  input logic        raw_sync,
  input logic        pol0,
  input logic        csync,
  input logic        cs_q,
  input logic        hb_q,
  input logic        vb_q,
  input logic        sc_q,
  input logic        bg_q
);
  localparam int V_W = $clog2(LINES);

  AST_HCNT_IN_LINE: assert property (@(posedge clk) disable iff (rst)
    hcnt < line_len); // R1

  AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (hcnt == line_len - 13'd1) |=> (hcnt == 13'd0 &&
      vcnt == (($past(vcnt) == V_W'(LINES - 1)) ? '0 : $past(vcnt) + V_W'(1)))); // R1

  AST_RAW_ROUTE: assert property (@(posedge clk) disable iff (rst)
    csync_raw_sel |=> (csync == (pol0 ? $past(raw_sync) : !$past(raw_sync)))); // R9

  AST_SYNC_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
    (cs_q && !$past(csync_raw_sel)) |-> (hb_q || vb_q)); // R6

  AST_SCLAMP_IN_HBLANK: assert property (@(posedge clk) disable iff (rst)
    sc_q |-> hb_q); // R3

  AST_BURST_IN_HBLANK: assert property (@(posedge clk) disable iff (rst)
    bg_q |-> hb_q); // R4
endmodule

bind cvp_sync_gen cvp_sync_gen_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst(rst), .hcnt(hcnt), .line_len(line_len), .vcnt(vcnt),
  .csync_raw_sel(csync_raw_sel), .raw_sync(raw_sync), .pol0(pol[0]),
  .csync(csync), .cs_q(cs_q), .hb_q(hb_q), .vb_q(vb_q), .sc_q(sc_q), .bg_q(bg_q)
);

// File: tb/cvp_sync_gen_tb.sv
module cvp_sync_gen_tb;
  localparam int LINES = 29;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] line_code = '0;
  logic        std_pal = 1'b0, vblank_long = 1'b0, progressive = 1'b1;
  logic [2:0]  pol = 3'b111;
  logic        burst_long = 1'b0, csync_raw_sel = 1'b0, raw_sync = 1'b0;
  logic        csync, hblank, vblank, sclamp, bclamp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cvp_sync_gen #(.LINES(LINES)) u_dut (
    .clk(clk), .rst(rst), .line_code(line_code), .std_pal(std_pal),
    .vblank_long(vblank_long), .progressive(progressive), .pol(pol),
    .burst_long(burst_long), .csync_raw_sel(csync_raw_sel), .raw_sync(raw_sync),
    .csync(csync), .hblank(hblank), .vblank(vblank), .sclamp(sclamp), .bclamp(bclamp)
  );

  function automatic int line_clocks();
    if (line_code == 0) return std_pal ? 3456 : 3432;
    return 2 * (int'(line_code) + 1024);
  endfunction

  function automatic logic [4:0] expect_at(int idx);
    int hl_len, h, v, half, hl, q, nb;
    logic cs, hb, vb, sc, bg, vs;
    hl_len = line_clocks();
    h = idx % hl_len;
    v = (idx / hl_len) % LINES;
    half = hl_len / 2;
    hl = 2 * v + ((h >= half) ? 1 : 0);
    q = (h >= half) ? h - half : h;
    nb = vblank_long ? 16 : 9;
    vs = (hl < 6) || (!progressive && hl >= LINES && hl < LINES + 6);
    vb = (hl < 2 * nb) || (!progressive && hl >= LINES && hl < LINES + 2 * nb);
    cs = vs ? (q < half - 128) : (h < 256);
    hb = (h < 560) || (h >= hl_len - 64);
    sc = (h >= 32) && (h < 224);
    bg = (h >= 288) && (h < 288 + (burst_long ? 256 : 128));
    return {pol[0] ? cs : !cs, pol[1] ? hb : !hb, pol[1] ? vb : !vb,
            pol[2] ? sc : !sc, pol[2] ? bg : !bg};
  endfunction

  task automatic restart(input string tag);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if ({csync, hblank, vblank, sclamp, bclamp} !==
        {!pol[0], !pol[1], !pol[1], !pol[2], !pol[2]}) begin
      errors++;
      $display("FAIL R10 %s reset levels: actual %b expected %b", tag,
               {csync, hblank, vblank, sclamp, bclamp},
               {!pol[0], !pol[1], !pol[1], !pol[2], !pol[2]});
    end
    rst = 1'b0;
  endtask

  task automatic sweep(input int ncyc, input string tag);
    string names [5] = '{"bclamp R3 R8", "sclamp R3 R8", "vblank R5 R7 R8",
                         "hblank R4 R8", "csync R6 R7 R8"};
    bit bad [5];
    logic fa [5];
    logic fe [5];
    int fi [5];
    int hl_len;
    logic [4:0] e, a;
    hl_len = line_clocks();
    for (int k = 0; k < 5; k++) bad[k] = 0;
    for (int idx = 0; idx < ncyc; idx++) begin
      @(negedge clk);
      e = expect_at(idx);
      a = {csync, hblank, vblank, sclamp, bclamp};
      for (int k = 0; k < 5; k++) begin
        if (a[k] !== e[k] && !bad[k]) begin
          bad[k] = 1; fa[k] = a[k]; fe[k] = e[k]; fi[k] = idx;
        end
      end
      if ((idx % hl_len) == hl_len - 1 || idx == ncyc - 1) begin
        for (int k = 0; k < 5; k++) begin
          checks++;
          if (bad[k]) begin
            errors++;
            $display("FAIL %s R1 %s line %0d cycle %0d: actual %b expected %b",
                     tag, names[k], idx / hl_len, fi[k], fa[k], fe[k]);
          end
          bad[k] = 0;
        end
      end
    end
  endtask

  initial begin
    // R1 R5 R8: progressive, 16 blank lines, mixed polarity, short burst, past frame wrap
    line_code = 11'd8; progressive = 1'b1; vblank_long = 1'b1;
    pol = 3'b101; burst_long = 1'b0; csync_raw_sel = 1'b0;
    restart("progA");
    sweep((LINES + 2) * 2064, "progA");

    // R7: interlaced, 9 blank lines, long burst, inverted sync polarity
    line_code = 11'd2; progressive = 1'b0; vblank_long = 1'b0;
    pol = 3'b010; burst_long = 1'b1;
    restart("intB");
    sweep((LINES + 2) * 2052, "intB");

    // R2: default line lengths for both standards
    line_code = 11'd0; std_pal = 1'b0; pol = 3'b111;
    restart("defN R2");
    sweep(2 * 3432 + 40, "defN R2");
    std_pal = 1'b1; pol = 3'b000;
    restart("defP R2");
    sweep(2 * 3456 + 40, "defP R2");

    // R9: raw sync routed to csync one edge later, active-low output
    line_code = 11'd8; progressive = 1'b1; pol = 3'b110;
    csync_raw_sel = 1'b1; raw_sync = 1'b1;
    restart("raw");
    begin
      logic prev;
      prev = raw_sync;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        checks++;
        if (csync !== !prev) begin
          errors++;
          $display("FAIL R9 raw step %0d: actual %b expected %b", i, csync, !prev);
        end
        raw_sync = ((i % 7) < 3) ^ ((i % 3) == 0);
        prev = raw_sync;
      end
    end
    pol = 3'b111;
    restart("rawB");
    begin
      logic prev;
      prev = raw_sync;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        checks++;
        if (csync !== prev) begin
          errors++;
          $display("FAIL R9 raw high-active step %0d: actual %b expected %b", i, csync, prev);
        end
        raw_sync = (i % 5) < 2;
        prev = raw_sync;
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule